// File: doc/BRIEF.md
# Fused-Entry Reorder Buffer

This block is a circular reorder buffer for an out-of-order core. Decoded operations enter one per cycle, in program order, through a valid/ready dispatch port. Each operation is written into the slot at the tail, and the slot index is returned as the operation's tag. One slot can hold a fused operation that needs work from several execution units. A subtract combined with a store is one example. The slot records a mask of the units it is waiting for.

Execution units report completion on their own ports in any order. Each report names the tag and carries a result value and a fault flag. A slot becomes retirable only after every unit named in its mask has reported.

Each cycle, up to three consecutive retirable entries leave from the head. Each one drives a commit port toward the architectural register file. A fault reported for an entry is held until that entry is the oldest. When it reaches the head, the buffer raises a one-cycle exception carrying the tag, discards that entry and everything younger, and returns to empty.

Top module: `fused_rob`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, `cm_ret` is all zero and `exc_valid` is 0.
- R2: Each accepted dispatch (`disp_valid` and `disp_ready` both high at a clock edge) takes the slot shown on `disp_tag`. The tag then advances by one modulo DEPTH, so entries are numbered in program order.
- R3: With DEPTH entries outstanding, `disp_ready` is 0 and no further operation is accepted. `disp_ready` returns to 1 in the cycle after the head entry retires.
- R4: `disp_need` bit 0 means ALU, bit 1 means multiplier and bit 2 means store unit. A report on completion port u sets bit u of the entry's done set. An entry is retirable only when every bit set in its need mask has been reported.
- R5: Retirement takes entries strictly in order from the head, at most three per cycle. It stops at the first entry that is not retirable. Retiring entries appear on commit ports 0, 1 and 2 in order, oldest on port 0, and `cm_ret` is always a contiguous run starting at bit 0.
- R6: The result committed for an entry is the value from its most recent report on a result-producing unit (ALU or multiplier). Data on the store unit's port is never used as a result.
- R7: `cm_we[k]` is 1 only if entry k has a destination. It is also suppressed when a younger entry retiring in the same cycle writes the same register, so only the youngest write reaches a register.
- R8: A fault flag on a report marks the entry. When the marked entry is at the head, `exc_valid` pulses for one cycle with `exc_tag` equal to that entry. That entry and all younger entries never commit. In the next cycle the buffer is empty, with `disp_tag` equal to 0 and `disp_ready` equal to 1.
- R9: A completion report that names a slot holding no valid entry has no effect. This covers a slot that was never allocated and a slot that was flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Buffer can accept a dispatch |
| disp_need | input | N_UNITS | Units the operation needs (bit 0 ALU, 1 MUL, 2 store) |
| disp_has_dst | input | 1 | Operation writes a register |
| disp_dst | input | AREG_W | Destination register index |
| disp_tag | output | log2(DEPTH) | Slot given to the current dispatch |
| cmp_valid | input | N_UNITS | Completion report per unit |
| cmp_idx | input | N_UNITS*log2(DEPTH) | Tag per unit, unit u at slice u |
| cmp_data | input | N_UNITS*DATA_W | Result per unit |
| cmp_fault | input | N_UNITS | Fault flag per unit |
| cm_ret | output | RET_W | Commit port k retires an entry |
| cm_we | output | RET_W | Commit port k writes the register file |
| cm_tag | output | RET_W*log2(DEPTH) | Tag per commit port |
| cm_dst | output | RET_W*AREG_W | Destination per commit port |
| cm_data | output | RET_W*DATA_W | Result per commit port |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_tag | output | log2(DEPTH) | Tag of the faulting entry |

## Verification
The assertions check the pointer bookkeeping on every cycle: the occupancy bound, the head-to-tail distance, no acceptance while full, no allocation into a live slot, the retire count never exceeding occupancy, and the single-cycle exception that leaves the buffer empty. Other properties depend on the stimulus and only the bench's scenarios can show them. These are that fused entries wait for every unit in their mask, that retirement stops at a gap and caps at three, that a shared destination keeps only its youngest write, and that stray or post-flush reports change nothing. The scoreboard predicts every commit and exception from the dispatch and completion history alone.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    UNIT_ALU   = 2'd0,
    UNIT_MUL   = 2'd1,
    UNIT_STORE = 2'd2
  } unit_e;

  // Units whose completion report carries the entry's result value
  localparam logic [2:0] RESULT_MASK_DEF = 3'b011;

  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter  int DEPTH = 16,
  parameter  int RET_W = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1,
  localparam int NRW   = rob_pkg::cnt_width(RET_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [NRW-1:0]   pop_n,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [PTR_W-1:0] count,
  output logic             full
);

  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;
  logic [PTR_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  always_comb begin
    upd_en = push | (pop_n != '0) | flush;
    head_d = head_q + PTR_W'(pop_n);
    tail_d = tail_q + PTR_W'(push);
    cnt_d  = cnt_q + PTR_W'(push) - PTR_W'(pop_n);
    if (flush) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign count    = cnt_q;
  assign full     = (head_q[PTR_W-1] != tail_q[PTR_W-1]) &&
                    (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PTR_W'(DEPTH));

  // R3
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));

  // R2
  ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q - head_q) == cnt_q);

  // R5
  pop_le_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    PTR_W'(pop_n) <= cnt_q);

endmodule

// File: rtl/rob_slots.sv
module rob_slots #(
  parameter  int                 DEPTH        = 16,
  parameter  int                 N_UNITS      = 3,
  parameter  int                 RET_W        = 3,
  parameter  int                 DATA_W       = 32,
  parameter  int                 AREG_W       = 5,
  parameter  logic [N_UNITS-1:0] RESULT_UNITS = rob_pkg::RESULT_MASK_DEF,
  localparam int                 IDX_W        = $clog2(DEPTH),
  localparam int                 NRW          = rob_pkg::cnt_width(RET_W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc,
  input  logic [IDX_W-1:0]          alloc_idx,
  input  logic [N_UNITS-1:0]        alloc_need,
  input  logic                      alloc_has_dst,
  input  logic [AREG_W-1:0]         alloc_dst,
  input  logic [N_UNITS-1:0]        cmp_valid,
  input  logic [N_UNITS*IDX_W-1:0]  cmp_idx,
  input  logic [N_UNITS*DATA_W-1:0] cmp_data,
  input  logic [N_UNITS-1:0]        cmp_fault,
  input  logic [IDX_W-1:0]          head_idx,
  input  logic [NRW-1:0]            pop_n,
  input  logic                      flush,
  output logic [RET_W-1:0]          win_valid,
  output logic [RET_W-1:0]          win_complete,
  output logic [RET_W-1:0]          win_fault,
  output logic [RET_W-1:0]          win_has_dst,
  output logic [RET_W*AREG_W-1:0]   win_dst,
  output logic [RET_W*DATA_W-1:0]   win_data
);

  logic [DEPTH-1:0]   vld_q, vld_d;
  logic [DEPTH-1:0]   flt_q, flt_d;
  logic [DEPTH-1:0]   hd_q, hd_d;
  logic [N_UNITS-1:0] need_q [DEPTH];
  logic [N_UNITS-1:0] need_d [DEPTH];
  logic [N_UNITS-1:0] done_q [DEPTH];
  logic [N_UNITS-1:0] done_d [DEPTH];
  logic [AREG_W-1:0]  dst_q  [DEPTH];
  logic [AREG_W-1:0]  dst_d  [DEPTH];
  logic [DATA_W-1:0]  dat_q  [DEPTH];
  logic [DATA_W-1:0]  dat_d  [DEPTH];

  // Next state: completion merge, then retire/flush clear, then allocation
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      logic [IDX_W-1:0] off;
      vld_d[e]  = vld_q[e];
      flt_d[e]  = flt_q[e];
      hd_d[e]   = hd_q[e];
      need_d[e] = need_q[e];
      done_d[e] = done_q[e];
      dst_d[e]  = dst_q[e];
      dat_d[e]  = dat_q[e];
      for (int u = 0; u < N_UNITS; u++) begin
        if (cmp_valid[u] && vld_q[e] &&
            (cmp_idx[u*IDX_W +: IDX_W] == IDX_W'(e))) begin
          done_d[e][u] = 1'b1;
          if (cmp_fault[u]) flt_d[e] = 1'b1;
          if (RESULT_UNITS[u]) dat_d[e] = cmp_data[u*DATA_W +: DATA_W];
        end
      end
      off = IDX_W'(e) - head_idx;
      if (flush || (int'(off) < int'(pop_n))) begin
        vld_d[e] = 1'b0;
        flt_d[e] = 1'b0;
      end
      if (alloc && (alloc_idx == IDX_W'(e))) begin
        vld_d[e]  = 1'b1;
        flt_d[e]  = 1'b0;
        hd_d[e]   = alloc_has_dst;
        need_d[e] = alloc_need;
        done_d[e] = '0;
        dst_d[e]  = alloc_dst;
        dat_d[e]  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      flt_q <= '0;
      hd_q  <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        need_q[e] <= '0;
        done_q[e] <= '0;
      end
    end else begin
      vld_q <= vld_d;
      flt_q <= flt_d;
      hd_q  <= hd_d;
      for (int e = 0; e < DEPTH; e++) begin
        need_q[e] <= need_d[e];
        done_q[e] <= done_d[e];
      end
    end
  end

  // Datapath storage, no reset
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      dst_q[e] <= dst_d[e];
      dat_q[e] <= dat_d[e];
    end
  end

  // Retire window: the RET_W slots starting at the head
  for (genvar k = 0; k < RET_W; k++) begin : g_win
    logic [IDX_W-1:0] widx;
    assign widx            = head_idx + IDX_W'(k);
    assign win_valid[k]    = vld_q[widx];
    assign win_complete[k] = vld_q[widx] && ((need_q[widx] & ~done_q[widx]) == '0);
    assign win_fault[k]    = flt_q[widx];
    assign win_has_dst[k]  = hd_q[widx];
    assign win_dst[k*AREG_W +: AREG_W] = dst_q[widx];
    assign win_data[k*DATA_W +: DATA_W] = dat_q[widx];
  end

  // R2
  alloc_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !vld_q[alloc_idx]);

endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
  parameter  int DEPTH  = 16,
  parameter  int RET_W  = 3,
  parameter  int DATA_W = 32,
  parameter  int AREG_W = 5,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int NRW    = rob_pkg::cnt_width(RET_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [RET_W-1:0]        win_valid,
  input  logic [RET_W-1:0]        win_complete,
  input  logic [RET_W-1:0]        win_fault,
  input  logic [RET_W-1:0]        win_has_dst,
  input  logic [RET_W*AREG_W-1:0] win_dst,
  input  logic [RET_W*DATA_W-1:0] win_data,
  input  logic [IDX_W-1:0]        head_idx,
  input  logic [PTR_W-1:0]        count,
  output logic [NRW-1:0]          pop_n,
  output logic                    flush,
  output logic                    exc_valid,
  output logic [IDX_W-1:0]        exc_tag,
  output logic [RET_W-1:0]        cm_ret,
  output logic [RET_W-1:0]        cm_we,
  output logic [RET_W*IDX_W-1:0]  cm_tag,
  output logic [RET_W*AREG_W-1:0] cm_dst,
  output logic [RET_W*DATA_W-1:0] cm_data
);

  logic [RET_W-1:0] ok;

  // In-order chain: stop at the first slot that is absent, incomplete or faulted
  always_comb begin
    logic go;
    go    = 1'b1;
    pop_n = '0;
    for (int k = 0; k < RET_W; k++) begin
      ok[k] = go && (int'(count) > k) && win_valid[k] &&
              win_complete[k] && !win_fault[k];
      go    = ok[k];
      if (ok[k]) pop_n = pop_n + NRW'(1);
    end
  end

  // Youngest write to a register wins within one retire group
  always_comb begin
    for (int k = 0; k < RET_W; k++) begin
      logic shadowed;
      shadowed = 1'b0;
      for (int j = k + 1; j < RET_W; j++) begin
        if (ok[j] && win_has_dst[j] &&
            (win_dst[j*AREG_W +: AREG_W] == win_dst[k*AREG_W +: AREG_W]))
          shadowed = 1'b1;
      end
      cm_we[k] = ok[k] && win_has_dst[k] && !shadowed;
    end
  end

  for (genvar k = 0; k < RET_W; k++) begin : g_port
    assign cm_tag[k*IDX_W +: IDX_W] = head_idx + IDX_W'(k);
  end

  assign cm_ret    = ok;
  assign cm_dst    = win_dst;
  assign cm_data   = win_data;
  assign flush     = (count != '0) && win_valid[0] && win_fault[0];
  assign exc_valid = flush;
  assign exc_tag   = head_idx;

  // R8
  exc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid);

  // R8
  exc_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (count == '0));

endmodule

// File: rtl/fused_rob.sv
module fused_rob #(
  parameter  int                 DEPTH        = 16,
  parameter  int                 N_UNITS      = 3,
  parameter  int                 RET_W        = 3,
  parameter  int                 DATA_W       = 32,
  parameter  int                 AREG_W       = 5,
  parameter  logic [N_UNITS-1:0] RESULT_UNITS = rob_pkg::RESULT_MASK_DEF,
  localparam int                 IDX_W        = $clog2(DEPTH),
  localparam int                 PTR_W        = IDX_W + 1,
  localparam int                 NRW          = rob_pkg::cnt_width(RET_W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      disp_valid,
  output logic                      disp_ready,
  input  logic [N_UNITS-1:0]        disp_need,
  input  logic                      disp_has_dst,
  input  logic [AREG_W-1:0]         disp_dst,
  output logic [IDX_W-1:0]          disp_tag,
  input  logic [N_UNITS-1:0]        cmp_valid,
  input  logic [N_UNITS*IDX_W-1:0]  cmp_idx,
  input  logic [N_UNITS*DATA_W-1:0] cmp_data,
  input  logic [N_UNITS-1:0]        cmp_fault,
  output logic [RET_W-1:0]          cm_ret,
  output logic [RET_W-1:0]          cm_we,
  output logic [RET_W*IDX_W-1:0]    cm_tag,
  output logic [RET_W*AREG_W-1:0]   cm_dst,
  output logic [RET_W*DATA_W-1:0]   cm_data,
  output logic                      exc_valid,
  output logic [IDX_W-1:0]          exc_tag
);

  logic                    push;
  logic                    flush;
  logic                    full;
  logic [NRW-1:0]          pop_n;
  logic [IDX_W-1:0]        head_idx;
  logic [IDX_W-1:0]        tail_idx;
  logic [PTR_W-1:0]        count;
  logic [RET_W-1:0]        win_valid;
  logic [RET_W-1:0]        win_complete;
  logic [RET_W-1:0]        win_fault;
  logic [RET_W-1:0]        win_has_dst;
  logic [RET_W*AREG_W-1:0] win_dst;
  logic [RET_W*DATA_W-1:0] win_data;

  assign disp_ready = !full && !flush;
  assign push       = disp_valid && disp_ready;
  assign disp_tag   = tail_idx;

  rob_ptr_ctrl #(.DEPTH(DEPTH), .RET_W(RET_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop_n    (pop_n),
    .flush    (flush),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .count    (count),
    .full     (full)
  );

  rob_slots #(
    .DEPTH(DEPTH), .N_UNITS(N_UNITS), .RET_W(RET_W),
    .DATA_W(DATA_W), .AREG_W(AREG_W), .RESULT_UNITS(RESULT_UNITS)
  ) u_slots (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc         (push),
    .alloc_idx     (tail_idx),
    .alloc_need    (disp_need),
    .alloc_has_dst (disp_has_dst),
    .alloc_dst     (disp_dst),
    .cmp_valid     (cmp_valid),
    .cmp_idx       (cmp_idx),
    .cmp_data      (cmp_data),
    .cmp_fault     (cmp_fault),
    .head_idx      (head_idx),
    .pop_n         (pop_n),
    .flush         (flush),
    .win_valid     (win_valid),
    .win_complete  (win_complete),
    .win_fault     (win_fault),
    .win_has_dst   (win_has_dst),
    .win_dst       (win_dst),
    .win_data      (win_data)
  );

  rob_retire #(
    .DEPTH(DEPTH), .RET_W(RET_W), .DATA_W(DATA_W), .AREG_W(AREG_W)
  ) u_ret (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_valid    (win_valid),
    .win_complete (win_complete),
    .win_fault    (win_fault),
    .win_has_dst  (win_has_dst),
    .win_dst      (win_dst),
    .win_data     (win_data),
    .head_idx     (head_idx),
    .count        (count),
    .pop_n        (pop_n),
    .flush        (flush),
    .exc_valid    (exc_valid),
    .exc_tag      (exc_tag),
    .cm_ret       (cm_ret),
    .cm_we        (cm_we),
    .cm_tag       (cm_tag),
    .cm_dst       (cm_dst),
    .cm_data      (cm_data)
  );

  // R8
  exc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (disp_tag == '0) && disp_ready);

  // R5
  no_commit_with_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (cm_ret == '0));

endmodule

// File: tb/fused_rob_test.sv
module fused_rob_test;

  localparam int D  = 16;
  localparam int IW = 4;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk;
  logic          rst_n;
  logic          disp_valid;
  logic          disp_ready;
  logic [2:0]    disp_need;
  logic          disp_has_dst;
  logic [AW-1:0] disp_dst;
  logic [IW-1:0] disp_tag;
  logic [2:0]    cmp_valid;
  logic [3*IW-1:0] cmp_idx;
  logic [3*DW-1:0] cmp_data;
  logic [2:0]    cmp_fault;
  logic [2:0]    cm_ret;
  logic [2:0]    cm_we;
  logic [3*IW-1:0] cm_tag;
  logic [3*AW-1:0] cm_dst;
  logic [3*DW-1:0] cm_data;
  logic          exc_valid;
  logic [IW-1:0] exc_tag;

  fused_rob uut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_need(disp_need),
    .disp_has_dst(disp_has_dst), .disp_dst(disp_dst), .disp_tag(disp_tag),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_data(cmp_data),
    .cmp_fault(cmp_fault),
    .cm_ret(cm_ret), .cm_we(cm_we), .cm_tag(cm_tag), .cm_dst(cm_dst),
    .cm_data(cm_data), .exc_valid(exc_valid), .exc_tag(exc_tag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int vectors = 0;
  int fails   = 0;

  // Scoreboard state, indexed by tag
  int            exp_q[$];
  int            exc_q[$];
  logic [AW-1:0] e_dst [D];
  logic          e_hd  [D];
  logic [DW-1:0] e_dat [D];

  task automatic chk(input bit good, input string req, input longint act, input longint exp);
    vectors++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected commits and exceptions as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      int  ptag [3];
      bit  pok  [3];
      for (int k = 0; k < 3; k++) begin
        pok[k]  = 1'b0;
        ptag[k] = 0;
        if (cm_ret[k]) begin
          if (k > 0) chk(cm_ret[k-1], "R5 contiguous", cm_ret, 0);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected commit", cm_tag[k*IW +: IW], 99);
          end else begin
            ptag[k] = exp_q.pop_front();
            pok[k]  = 1'b1;
          end
        end
      end
      for (int k = 0; k < 3; k++) begin
        if (pok[k]) begin
          bit xw;
          xw = e_hd[ptag[k]];
          for (int j = k + 1; j < 3; j++)
            if (pok[j] && e_hd[ptag[j]] && (e_dst[ptag[j]] == e_dst[ptag[k]])) xw = 1'b0;
          chk(cm_tag[k*IW +: IW] == IW'(ptag[k]), "R5 tag", cm_tag[k*IW +: IW], ptag[k]);
          chk(cm_data[k*DW +: DW] == e_dat[ptag[k]], "R6 data", cm_data[k*DW +: DW], e_dat[ptag[k]]);
          chk(cm_we[k] == xw, "R7 we", cm_we[k], xw);
          if (xw) chk(cm_dst[k*AW +: AW] == e_dst[ptag[k]], "R7 dst", cm_dst[k*AW +: AW], e_dst[ptag[k]]);
        end
      end
      if (exc_valid) begin
        if (exc_q.size() == 0) chk(1'b0, "R8 unexpected exc", exc_tag, 99);
        else begin
          int et;
          et = exc_q.pop_front();
          chk(exc_tag == IW'(et), "R8 exc tag", exc_tag, et);
        end
      end
    end
  end

  task automatic dispatch(input logic [2:0] need, input logic hd, input logic [AW-1:0] dst,
                          output int tag);
    disp_valid   = 1'b1;
    disp_need    = need;
    disp_has_dst = hd;
    disp_dst     = dst;
    while (!disp_ready) @(negedge clk);
    tag        = int'(disp_tag);
    e_dst[tag] = dst;
    e_hd[tag]  = hd;
    e_dat[tag] = '0;
    exp_q.push_back(tag);
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic complete(input int unit, input int tag, input logic [DW-1:0] data,
                          input logic fault);
    cmp_valid[unit]            = 1'b1;
    cmp_idx[unit*IW +: IW]     = IW'(tag);
    cmp_data[unit*DW +: DW]    = data;
    cmp_fault[unit]            = fault;
    if (fault) begin
      int pos;
      pos = -1;
      foreach (exp_q[i]) if (exp_q[i] == tag && pos < 0) pos = i;
      if (pos >= 0) begin
        while (exp_q.size() > pos) void'(exp_q.pop_back());
        exc_q.push_back(tag);
      end
    end else if (unit != 2) begin
      e_dat[tag] = data;
    end
    @(negedge clk);
    cmp_valid[unit] = 1'b0;
    cmp_fault[unit] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_tests();
    int t [20];
    // R1 reset state
    chk(disp_ready == 1'b1, "R1 ready", disp_ready, 1);
    chk(disp_tag == '0, "R1 tag", disp_tag, 0);
    chk(cm_ret == '0, "R1 ret", cm_ret, 0);
    chk(exc_valid == 1'b0, "R1 exc", exc_valid, 0);

    // R2 in-order tags, R5 stop at gap and group of three
    for (int i = 0; i < 3; i++) dispatch(3'b001, 1'b1, AW'(i + 1), t[i]);
    for (int i = 0; i < 3; i++) chk(t[i] == i, "R2 tag order", t[i], i);
    complete(0, t[2], 32'h1002, 1'b0);
    complete(0, t[1], 32'h1001, 1'b0);
    chk(cm_ret == '0, "R5 gap blocks", cm_ret, 0);
    complete(0, t[0], 32'h1000, 1'b0);
    chk(cm_ret == 3'b111, "R5 three retire", cm_ret, 3'b111);
    idle(1);

    // R5 cap at three per cycle
    for (int i = 0; i < 5; i++) dispatch(3'b001, 1'b1, AW'(8 + i), t[i]);
    for (int i = 4; i >= 1; i--) complete(0, t[i], DW'(32'h2000 + i), 1'b0);
    complete(0, t[0], 32'h2000, 1'b0);
    chk(cm_ret == 3'b111, "R5 first group", cm_ret, 3'b111);
    idle(1);
    chk(cm_ret == 3'b011, "R5 second group", cm_ret, 3'b011);
    idle(1);

    // R7 same destination, youngest wins; no-destination entry
    dispatch(3'b001, 1'b1, 5'd7, t[0]);
    dispatch(3'b001, 1'b1, 5'd7, t[1]);
    dispatch(3'b001, 1'b1, 5'd3, t[2]);
    complete(0, t[2], 32'h3002, 1'b0);
    complete(0, t[1], 32'h3001, 1'b0);
    complete(0, t[0], 32'h3000, 1'b0);
    chk(cm_we == 3'b110, "R7 shadowed write", cm_we, 3'b110);
    idle(1);
    dispatch(3'b001, 1'b0, 5'd9, t[0]);
    complete(0, t[0], 32'h3100, 1'b0);
    chk(cm_ret == 3'b001 && cm_we == 3'b000, "R7 no dst", {cm_ret, cm_we}, 6'b001000);
    idle(1);

    // R4 fused ALU + store; R6 store data ignored
    dispatch(3'b101, 1'b1, 5'd4, t[0]);
    complete(0, t[0], 32'hA5A5_0001, 1'b0);
    idle(3);
    chk(cm_ret == '0, "R4 waits for store", cm_ret, 0);
    complete(2, t[0], 32'hDEAD_BEEF, 1'b0);
    chk(cm_ret == 3'b001, "R4 fused retire", cm_ret, 3'b001);
    chk(cm_data[DW-1:0] == 32'hA5A5_0001, "R6 store ignored", cm_data[DW-1:0], 32'hA5A5_0001);
    idle(1);
    // R4 R6 multiplier then ALU, last result report kept
    dispatch(3'b011, 1'b1, 5'd5, t[0]);
    complete(1, t[0], 32'h0000_4444, 1'b0);
    chk(cm_ret == '0, "R4 waits for alu", cm_ret, 0);
    complete(0, t[0], 32'h0000_5555, 1'b0);
    idle(1);

    // R9 stray report to an unallocated slot
    dispatch(3'b001, 1'b1, 5'd6, t[0]);
    t[1] = int'(disp_tag);
    complete(0, t[1], 32'h6666, 1'b0);
    idle(2);
    chk(cm_ret == '0, "R9 stray ignored", cm_ret, 0);
    chk(int'(disp_tag) == t[1], "R9 tail unchanged", disp_tag, t[1]);
    complete(0, t[0], 32'h6000, 1'b0);
    idle(1);

    // R3 full buffer stalls dispatch
    for (int i = 0; i < D; i++) dispatch(3'b001, 1'b0, 5'd0, t[i]);
    chk(disp_ready == 1'b0, "R3 full", disp_ready, 0);
    disp_valid = 1'b1;
    idle(3);
    chk(disp_ready == 1'b0, "R3 stays full", disp_ready, 0);
    disp_valid = 1'b0;
    complete(0, t[0], 32'h7000, 1'b0);
    idle(1);
    chk(disp_ready == 1'b1, "R3 ready after retire", disp_ready, 1);
    for (int i = D - 1; i >= 1; i--) complete(0, t[i], DW'(32'h7000 + i), 1'b0);
    idle(6);

    // R8 fault held to head, younger discarded
    dispatch(3'b001, 1'b1, 5'd10, t[0]);
    dispatch(3'b001, 1'b1, 5'd11, t[1]);
    dispatch(3'b001, 1'b1, 5'd12, t[2]);
    complete(0, t[2], 32'h8002, 1'b0);
    complete(0, t[0], 32'h8000, 1'b0);
    complete(0, t[1], 32'h8001, 1'b1);
    chk(exc_valid == 1'b1, "R8 exc pulse", exc_valid, 1);
    idle(1);
    chk(exc_valid == 1'b0, "R8 pulse ends", exc_valid, 0);
    chk(disp_tag == '0 && disp_ready, "R8 empty after flush", {disp_ready, disp_tag}, 5'h10);
    // R9 report to a flushed slot
    complete(0, t[2], 32'h8888, 1'b0);
    idle(2);
    chk(cm_ret == '0, "R9 flushed ignored", cm_ret, 0);

    // R8 fault at head while younger entries complete
    dispatch(3'b001, 1'b1, 5'd13, t[0]);
    dispatch(3'b001, 1'b1, 5'd14, t[1]);
    complete(0, t[1], 32'h9001, 1'b0);
    complete(0, t[0], 32'h9000, 1'b1);
    idle(2);

    // R2 normal operation resumes at tag 0
    dispatch(3'b001, 1'b1, 5'd15, t[0]);
    chk(t[0] == 0, "R2 restart tag", t[0], 0);
    complete(0, t[0], 32'hA000, 1'b0);
    idle(3);

    chk(exp_q.size() == 0, "R5 all commits seen", exp_q.size(), 0);
    chk(exc_q.size() == 0, "R8 all exceptions seen", exc_q.size(), 0);
  endtask

  initial begin
    rst_n        = 1'b0;
    disp_valid   = 1'b0;
    disp_need    = '0;
    disp_has_dst = 1'b0;
    disp_dst     = '0;
    cmp_valid    = '0;
    cmp_idx      = '0;
    cmp_data     = '0;
    cmp_fault    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule